// File: doc/BRIEF.md
# Boot Region Write-Protection Checker

This block sits beside a flash controller and decides, for each modify request, whether the request must be refused because it would change the protected boot-loader area. A request is a page write, an erase or a whole-array erase aimed at a byte address in a two-bank flash. The protected area starts at the beginning of a bank. Its length comes from a 4-bit size code that counts down: each step below the all-ones code adds one 8 KB unit. When dual protection is active, the start of both banks is guarded instead of only the low half of the address space.

A startup pulse latches the configuration. A hard-lock fuse flag selects where the size code comes from: the value captured at lock time when the fuse is set, or the user-row fuse value when it is not. The dual-protection flag is taken only when the lock fuse is set. The bank-order bit is latched at the same time. Software can suspend protection for writes and erases with a set-disable command and can restore it with a clear-disable command. The hard lock overrides that suspension, and whole-array erase stays blocked while any protected area exists. The reject output is combinational from the current request and the latched state.

Top module: `boot_guard`

## Requirements
- R1: While reset is asserted, every status output reads 0. The size code is 0 (largest area) and no disable is in force.
- R2: A startup pulse with the lock fuse clear loads the size code from the user-row input and forces the dual flag to 0. Without a startup pulse the latched code keeps its value.
- R3: A startup pulse with the lock fuse set loads the size code from the locked-code input and the dual flag from the dual fuse input, and the lock status reads 1. The dual flag never reads 1 while the lock status is 0.
- R4: The protected length is (15 − code) × 8192 bytes. A write (reqOp=00) or erase (reqOp=01) whose offset within its 128 KB half, reqAddr[16:0], is below that length is rejected unless protection is suspended. Offsets at or above the length are accepted, and code 15 rejects nothing.
- R5: With the dual flag 0, addresses with reqAddr[17]=1 are never rejected for write or erase. With the dual flag 1, both halves are checked the same way.
- R6: A whole-array erase (reqOp=10) is rejected for every address whenever the code is not 15, even while protection is suspended. It is accepted when the code is 15.
- R7: After a set-disable, writes and erases in the area are accepted while the lock status is 0. A clear-disable restores protection. When both commands arrive in the same cycle, the clear wins.
- R8: A startup pulse clears the disable status and takes priority over a set-disable in the same cycle.
- R9: While the lock status is 1, writes and erases in the area are rejected even when the disable status is 1.
- R10: The bank-order status bit is the bankAFirst input latched at the startup pulse.
- R11: A request with reqValid=0, or with the no-op code reqOp=11, is never rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startupPulse | input | 1 | Latches the configuration and clears the disable |
| hardLockFuse | input | 1 | Hard-lock fuse is programmed |
| dualFuse | input | 1 | Dual-protection value recorded at lock time |
| userRowCode | input | 4 | Size code from the user-row fuses |
| lockedCode | input | 4 | Size code captured at lock time |
| bankAFirst | input | 1 | 1: bank A at address 0, 0: bank B at address 0 |
| setDisable | input | 1 | Command: suspend protection for writes and erases |
| clearDisable | input | 1 | Command: restore protection |
| reqValid | input | 1 | A modify request is present |
| reqOp | input | 2 | 00 write, 01 erase, 10 whole-array erase, 11 no-op |
| reqAddr | input | 18 | Byte address of the request |
| reqReject | output | 1 | Request hits protection and must be refused |
| stHardLock | output | 1 | Latched hard-lock status |
| stDualEn | output | 1 | Latched dual-protection status |
| stCode | output | 4 | Latched size code |
| stDisable | output | 1 | Protection-suspended status |
| stBankAFirst | output | 1 | Latched bank-order status |

## Verification
The assertions assume that startupPulse, setDisable and clearDisable are single-cycle pulses and that the configuration inputs are stable at the edge where startupPulse is high. The stimulus drives every input on the falling clock edge, so each input is held for a full cycle around the capturing edge. The disable-command properties rely on these pulses not overlapping startupPulse unless that overlap is the case under test. The bench sweeps every size code, both lock states, both dual states and both disable states. For each combination it probes addresses on both sides of each region boundary with all four operation codes.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_ERASE = 2'b01,
    OP_CHIP  = 2'b10,
    OP_NONE  = 2'b11
  } modOp_e;

  typedef struct packed {
    logic loadCfg;
    logic setDis;
    logic clrDis;
    logic reqModify;
    logic reqChip;
  } bpStrobe_t;

endpackage

// File: rtl/boot_guard_sizer.sv
module boot_guard_sizer #(
  parameter int CODE_W  = 4,
  parameter int UNIT_AW = 13,
  parameter int BANK_AW = 17
) (
  input  logic [CODE_W-1:0] code,
  output logic [BANK_AW:0]  sizeBytes,
  output logic              sizeNonZero
);
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};
  localparam int PAD_W = BANK_AW + 1 - CODE_W - UNIT_AW;

  logic [CODE_W-1:0] units;

  // Inverted code: all-ones means zero units.
  assign units       = MAX_CODE - code;
  assign sizeBytes   = {{PAD_W{1'b0}}, units, {UNIT_AW{1'b0}}};
  assign sizeNonZero = (units != '0);
endmodule

// File: rtl/boot_guard_ctrl.sv
module boot_guard_ctrl
  import boot_guard_pkg::*;
(
  input  logic      startupPulse,
  input  logic      setDisable,
  input  logic      clearDisable,
  input  logic      reqValid,
  input  logic [1:0] reqOp,
  output bpStrobe_t strobe
);
  modOp_e opDec;

  always_comb begin
    opDec            = modOp_e'(reqOp);
    strobe.loadCfg   = startupPulse;
    // Startup and clear both win over set.
    strobe.clrDis    = startupPulse | clearDisable;
    strobe.setDis    = setDisable & ~clearDisable & ~startupPulse;
    strobe.reqModify = reqValid & ((opDec == OP_WRITE) | (opDec == OP_ERASE));
    strobe.reqChip   = reqValid & (opDec == OP_CHIP);
  end
endmodule

// File: rtl/boot_guard_dp.sv
module boot_guard_dp
  import boot_guard_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int UNIT_AW = 13,
  parameter int BANK_AW = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strobe,
  input  logic              hardLockFuse,
  input  logic              dualFuse,
  input  logic [CODE_W-1:0] userRowCode,
  input  logic [CODE_W-1:0] lockedCode,
  input  logic              bankAFirst,
  input  logic [BANK_AW:0]  reqAddr,
  output logic              reqReject,
  output logic              stHardLock,
  output logic              stDualEn,
  output logic [CODE_W-1:0] stCode,
  output logic              stDisable,
  output logic              stBankAFirst
);
  logic              cfgHardLock, cfgDual, cfgAFirst, disFlag;
  logic [CODE_W-1:0] cfgCode;
  logic [BANK_AW:0]  sizeBytes;
  logic              sizeNonZero;
  logic [BANK_AW:0]  offset;
  logic              upperHalf, inRegion, guardActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgHardLock <= 1'b0;
      cfgDual     <= 1'b0;
      cfgCode     <= '0;
      cfgAFirst   <= 1'b0;
    end else if (strobe.loadCfg) begin
      cfgHardLock <= hardLockFuse;
      cfgDual     <= hardLockFuse & dualFuse;
      cfgCode     <= hardLockFuse ? lockedCode : userRowCode;
      cfgAFirst   <= bankAFirst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              disFlag <= 1'b0;
    else if (strobe.clrDis) disFlag <= 1'b0;
    else if (strobe.setDis) disFlag <= 1'b1;
  end

  boot_guard_sizer #(
    .CODE_W (CODE_W),
    .UNIT_AW(UNIT_AW),
    .BANK_AW(BANK_AW)
  ) sizer_i (
    .code       (cfgCode),
    .sizeBytes  (sizeBytes),
    .sizeNonZero(sizeNonZero)
  );

  always_comb begin
    offset      = {1'b0, reqAddr[BANK_AW-1:0]};
    upperHalf   = reqAddr[BANK_AW];
    inRegion    = (offset < sizeBytes) & (cfgDual | ~upperHalf);
    guardActive = ~disFlag | cfgHardLock;
    reqReject   = (strobe.reqChip & sizeNonZero)
                | (strobe.reqModify & inRegion & guardActive);
  end

  assign stHardLock   = cfgHardLock;
  assign stDualEn     = cfgDual;
  assign stCode       = cfgCode;
  assign stDisable    = disFlag;
  assign stBankAFirst = cfgAFirst;
endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import boot_guard_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int UNIT_AW = 13,
  parameter int BANK_AW = 17,
  localparam int ADDR_W = BANK_AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startupPulse,
  input  logic              hardLockFuse,
  input  logic              dualFuse,
  input  logic [CODE_W-1:0] userRowCode,
  input  logic [CODE_W-1:0] lockedCode,
  input  logic              bankAFirst,
  input  logic              setDisable,
  input  logic              clearDisable,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReject,
  output logic              stHardLock,
  output logic              stDualEn,
  output logic [CODE_W-1:0] stCode,
  output logic              stDisable,
  output logic              stBankAFirst
);
  bpStrobe_t strobe;

  boot_guard_ctrl ctrl_i (
    .startupPulse(startupPulse),
    .setDisable  (setDisable),
    .clearDisable(clearDisable),
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .strobe      (strobe)
  );

  boot_guard_dp #(
    .CODE_W (CODE_W),
    .UNIT_AW(UNIT_AW),
    .BANK_AW(BANK_AW)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hardLockFuse(hardLockFuse),
    .dualFuse    (dualFuse),
    .userRowCode (userRowCode),
    .lockedCode  (lockedCode),
    .bankAFirst  (bankAFirst),
    .reqAddr     (reqAddr),
    .reqReject   (reqReject),
    .stHardLock  (stHardLock),
    .stDualEn    (stDualEn),
    .stCode      (stCode),
    .stDisable   (stDisable),
    .stBankAFirst(stBankAFirst)
  );
endmodule

// File: rtl/boot_guard_chk.sv
module boot_guard_chk #(
  parameter int CODE_W  = 4,
  parameter int UNIT_AW = 13,
  parameter int BANK_AW = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              startupPulse,
  input logic              setDisable,
  input logic              clearDisable,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [BANK_AW:0]  reqAddr,
  input logic              reqReject,
  input logic              stHardLock,
  input logic              stDualEn,
  input logic [CODE_W-1:0] stCode,
  input logic              stDisable
);
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  AST_IDLE_NO_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqOp == 2'b11) |-> !reqReject); // R11

  AST_DUAL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !stHardLock |-> !stDualEn); // R3

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !startupPulse |=> $stable(stCode)); // R2

  AST_FULL_CODE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && stCode == MAX_CODE) |-> !reqReject); // R4

  AST_UPPER_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !stDualEn && reqAddr[BANK_AW] && reqOp != 2'b10) |-> !reqReject); // R5

  AST_CHIP_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b10 && stCode != MAX_CODE) |-> reqReject); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clearDisable |=> !stDisable); // R7

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (setDisable && !clearDisable && !startupPulse) |=> stDisable); // R7

  AST_STARTUP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startupPulse |=> !stDisable); // R8

  AST_LOCK_ENFORCES: assert property (@(posedge clk) disable iff (!rstN)
    (stHardLock && reqValid && !reqOp[1] && stCode != MAX_CODE &&
     reqAddr[BANK_AW-1:UNIT_AW] == '0 && (stDualEn || !reqAddr[BANK_AW]))
    |-> reqReject); // R9
endmodule

bind boot_guard boot_guard_chk #(
  .CODE_W (CODE_W),
  .UNIT_AW(UNIT_AW),
  .BANK_AW(BANK_AW)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .startupPulse(startupPulse),
  .setDisable  (setDisable),
  .clearDisable(clearDisable),
  .reqValid    (reqValid),
  .reqOp       (reqOp),
  .reqAddr     (reqAddr),
  .reqReject   (reqReject),
  .stHardLock  (stHardLock),
  .stDualEn    (stDualEn),
  .stCode      (stCode),
  .stDisable   (stDisable)
);

// File: tb/boot_guard_tb.sv
module boot_guard_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startupPulse = 1'b0, hardLockFuse = 1'b0, dualFuse = 1'b0;
  logic [3:0] userRowCode = '0, lockedCode = '0;
  logic       bankAFirst = 1'b0, setDisable = 1'b0, clearDisable = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = 2'b11;
  logic [17:0] reqAddr = '0;
  logic       reqReject, stHardLock, stDualEn, stDisable, stBankAFirst;
  logic [3:0] stCode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  boot_guard dut_i (
    .clk(clk), .rstN(rstN), .startupPulse(startupPulse),
    .hardLockFuse(hardLockFuse), .dualFuse(dualFuse),
    .userRowCode(userRowCode), .lockedCode(lockedCode),
    .bankAFirst(bankAFirst), .setDisable(setDisable),
    .clearDisable(clearDisable), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqReject(reqReject), .stHardLock(stHardLock),
    .stDualEn(stDualEn), .stCode(stCode), .stDisable(stDisable),
    .stBankAFirst(stBankAFirst)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startup(input bit hl, input bit dual, input int ur,
                         input int lk, input bit af);
    @(negedge clk);
    hardLockFuse = hl; dualFuse = dual;
    userRowCode = 4'(ur); lockedCode = 4'(lk); bankAFirst = af;
    startupPulse = 1'b1;
    @(negedge clk);
    startupPulse = 1'b0;
  endtask

  task automatic cmd(input bit s, input bit c, input bit st);
    @(negedge clk);
    setDisable = s; clearDisable = c; startupPulse = st;
    @(negedge clk);
    setDisable = 1'b0; clearDisable = 1'b0; startupPulse = 1'b0;
  endtask

  function automatic int expReject(bit hl, bit dual, int code, bit dis,
                                   int op, int addr, bit valid);
    int size;
    bit hit;
    size = (15 - code) * 8192;
    if (!valid || op == 3) return 0;
    if (op == 2) return (size != 0) ? 1 : 0;
    hit = ((addr % 131072) < size) && ((hl && dual) || addr < 131072);
    return (hit && (!dis || hl)) ? 1 : 0;
  endfunction

  function automatic string tagFor(bit hl, bit dis, int op, int addr);
    if (op == 3)       return "R11";
    if (op == 2)       return "R6";
    if (hl && dis)     return "R9";
    if (dis)           return "R7";
    if (addr >= 131072) return "R5";
    return "R4";
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int addrs[7];
    #5;
    // R1 reset state
    check("R1 code", stCode, 0);
    check("R1 lock", stHardLock, 0);
    check("R1 dual", stDualEn, 0);
    check("R1 dis", stDisable, 0);
    check("R1 afirst", stBankAFirst, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;

    // R7 clear wins over set, then set and clear separately
    cmd(1, 1, 0); check("R7 both", stDisable, 0);
    cmd(1, 0, 0); check("R7 set", stDisable, 1);
    cmd(0, 1, 0); check("R7 clear", stDisable, 0);
    // R8 startup beats set
    cmd(1, 0, 1); check("R8 startup", stDisable, 0);
    cmd(1, 0, 0);
    startup(0, 0, 5, 9, 1);
    check("R8 after startup", stDisable, 0);
    check("R10 afirst", stBankAFirst, 1);
    startup(0, 0, 5, 9, 0);
    check("R10 bfirst", stBankAFirst, 0);
    // R2 code holds without startup
    lockedCode = 4'd1; userRowCode = 4'd2;
    @(negedge clk); @(negedge clk);
    check("R2 hold", stCode, 5);

    for (int hl = 0; hl < 2; hl++)
      for (int dual = 0; dual < 2; dual++)
        for (int code = 0; code < 16; code++)
          for (int dis = 0; dis < 2; dis++) begin
            int size;
            startup(hl[0], dual[0], hl ? (15 - code) : code,
                    hl ? code : (15 - code), 1'(code));
            if (hl) begin
              check("R3 code", stCode, code);
              check("R3 lock", stHardLock, 1);
              check("R3 dual", stDualEn, dual);
            end else begin
              check("R2 code", stCode, code);
              check("R2 lock", stHardLock, 0);
              check("R2 dual", stDualEn, 0);
            end
            if (dis) cmd(1, 0, 0);
            check("R7 dis state", stDisable, dis);
            size = (15 - code) * 8192;
            addrs = '{0, size - 1, size, 131072, 131072 + size - 1,
                      131072 + size, 262143};
            for (int op = 0; op < 4; op++)
              foreach (addrs[k]) begin
                if (addrs[k] < 0 || addrs[k] > 262143) continue;
                reqValid = 1'b1; reqOp = 2'(op); reqAddr = 18'(addrs[k]);
                #2;
                check(tagFor(hl[0], dis[0], op, addrs[k]), reqReject,
                      expReject(hl[0], dual[0], code, dis[0], op, addrs[k], 1'b1));
                reqValid = 1'b0;
                #1;
                check("R11 idle", reqReject, 0);
              end
            @(negedge clk);
          end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule